// File: doc/BRIEF.md
# I2C Event Interrupt Vector Unit

This block gathers the event pulses of an I2C master controller into a sticky status register. It qualifies them with an enable mask and presents the highest-priority pending, enabled event as a small numeric vector. A registered interrupt request line goes high whenever any enabled event is pending. Software services the controller by reading the vector repeatedly. Each read consumes the event it reports, and the loop ends when the vector reads 0.

The seven events, with their vector codes, are: arbitration lost (1), no-acknowledge (2), access ready (3), receive data ready (4), transmit data ready (5), stop condition detected (6), and addressed as slave (7). Each event has a status bit and a mask bit at position code minus one. A lower code has the higher priority. Status bits can also be cleared by writing ones to them.

Top module: `i2c_evt_vector`

## Requirements
- R1: After reset, the status register, the mask register, the vector and the interrupt line are all zero.
- R2: A one-cycle pulse on `evt_set[i]` sets status bit i, and the bit is visible on `status` the cycle after the pulse. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop detected 5, addressed as slave 6.
- R3: `vec` carries i+1 for the lowest i whose status bit and mask bit are both set, giving codes 1 to 7 as listed above. When no such i exists, `vec` is 0.
- R4: A pending status bit whose mask bit is 0 stays in `status`. It does not affect `vec` or `irq`.
- R5: A write with `wr_sel`=1 clears every status bit where `wr_data` is 1. Bits where `wr_data` is 0 keep their value.
- R6: A write with `wr_sel`=0 loads `wr_data` into the mask register, visible on `mask` the next cycle.
- R7: A `vec_rd` strobe while `vec` is nonzero clears the status bit of the reported event, so the next read returns the next pending event. A strobe while `vec` is 0 changes nothing.
- R8: If a set pulse and a clear (by write-one or by vector read) hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is registered. It equals the OR of (status AND mask) as it stood in the previous cycle, so it rises and falls one cycle after the pending set changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | EVT_N | One-cycle event set pulses from the protocol engine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mask, 1 status (write-one-to-clear) |
| wr_data | input | EVT_N | Write data |
| vec_rd | input | 1 | Vector read strobe; consumes the reported event |
| vec | output | VW | Code of the highest-priority enabled pending event, 0 if none |
| irq | output | 1 | Registered interrupt request |
| status | output | EVT_N | Current status register |
| mask | output | EVT_N | Current mask register |

## Verification
The bench builds the block with its default of seven events and a three-bit vector. This brings every code from 1 to 7 within reach, along with the empty code 0. Multi-event drain sequences show that priority order follows the code numbering. Partial masks separate what is pending from what is reported, and same-cycle set/clear collisions exercise both clear paths.

// File: rtl/i2c_evt_vector.sv
module i2c_evt_vector #(
  parameter int EVT_N = 7,
  parameter int VW    = $clog2(EVT_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_set,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [EVT_N-1:0] wr_data,
  input  logic             vec_rd,
  output logic [VW-1:0]    vec,
  output logic             irq,
  output logic [EVT_N-1:0] status,
  output logic [EVT_N-1:0] mask
);
  logic [EVT_N-1:0] stat_q, mask_q, act, w1c, rd_clr;
  logic [VW-1:0]    code;
  logic             irq_q;

  assign act = stat_q & mask_q;

  always_comb begin
    code = '0;
    for (int i = EVT_N - 1; i >= 0; i--)
      if (act[i]) code = VW'(i + 1);
  end

  assign w1c    = (wr_en && wr_sel) ? wr_data : '0;
  assign rd_clr = (vec_rd && code != '0) ? (EVT_N'(1) << (code - VW'(1))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~(w1c | rd_clr)) | evt_set;
      if (wr_en && !wr_sel) mask_q <= wr_data;
      irq_q  <= |act;
    end
  end

  assign vec    = code;
  assign irq    = irq_q;
  assign status = stat_q;
  assign mask   = mask_q;
endmodule

// File: rtl/i2c_evt_vector_chk.sv
module i2c_evt_vector_chk #(
  parameter int EVT_N = 7,
  parameter int VW    = $clog2(EVT_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_N-1:0] evt_set,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [EVT_N-1:0] wr_data,
  input logic             vec_rd,
  input logic [VW-1:0]    vec,
  input logic             irq,
  input logic [EVT_N-1:0] status,
  input logic [EVT_N-1:0] mask
);
  logic [EVT_N-1:0] rep_bit;
  assign rep_bit = (vec != '0) ? (EVT_N'(1) << (vec - VW'(1))) : '0;

  // R3: empty vector exactly when nothing enabled is pending
  always_comb
    if (rst_n) a_r3_vec_empty: assert ((vec == '0) == ((status & mask) == '0));

  a_r4_reported_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    vec != '0 |-> (rep_bit & status & mask) == rep_bit);

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set != '0 |=> (status & $past(evt_set)) == $past(evt_set));

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> (status & $past(wr_data & ~evt_set)) == '0);

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> mask == $past(wr_data));

  a_r7_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && vec != '0 && (rep_bit & evt_set) == '0 |=> (status & $past(rep_bit)) == '0);

  a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(status & mask)));
endmodule

bind i2c_evt_vector i2c_evt_vector_chk #(.EVT_N(EVT_N), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .vec_rd(vec_rd), .vec(vec), .irq(irq), .status(status),
  .mask(mask)
);

// File: tb/sim_i2c_evt_vector.sv
module sim_i2c_evt_vector;
  localparam int N = 7;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_set = '0, wr_data = '0;
  logic wr_en = 1'b0, wr_sel = 1'b0, vec_rd = 1'b0;
  logic [2:0] vec;
  logic irq;
  logic [N-1:0] status, mask;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_evt_vector u0 (.clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .vec_rd(vec_rd), .vec(vec), .irq(irq),
    .status(status), .mask(mask));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [N-1:0] s);
    evt_set = s;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic wr(logic sel, logic [N-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(output int v);
    v = vec;
    vec_rd = 1'b1;
    @(negedge clk);
    vec_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0);
    chk("R1 mask", mask, 0);
    chk("R1 vec", vec, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_map;
    wr(1'b0, 7'h7f);
    chk("R6 mask all", mask, 7'h7f);
    for (int i = 0; i < N; i++) begin
      pulse(N'(1) << i);
      chk("R2 bit", status, 1 << i);
      chk("R3 code", vec, i + 1);
      wr(1'b1, N'(1) << i);
      chk("R5 cleared", status, 0);
    end
    @(negedge clk);
  endtask

  task automatic t_drain;
    int v;
    pulse(7'b1010110);
    chk("R3 first", vec, 2);
    rd(v); chk("R7 read1", v, 2);
    rd(v); chk("R7 read2", v, 3);
    rd(v); chk("R7 read3", v, 5);
    rd(v); chk("R7 read4", v, 7);
    rd(v); chk("R7 read empty", v, 0);
    chk("R7 status empty", status, 0);
    pulse(7'b0100000);
    wr(1'b1, 7'b0000000);
    chk("R5 zero write keeps", status, 7'b0100000);
    wr(1'b1, 7'b0100000);
    @(negedge clk);
  endtask

  task automatic t_mask;
    int v;
    wr(1'b0, 7'b0000100);
    pulse(7'b0000101);
    chk("R4 vec masked", vec, 3);
    chk("R4 status holds", status, 7'b0000101);
    @(negedge clk);
    chk("R9 irq high", irq, 1);
    rd(v);
    chk("R7 reported", v, 3);
    chk("R4 vec none enabled", vec, 0);
    chk("R4 AL pending", status, 7'b0000001);
    chk("R9 irq lag", irq, 1);
    @(negedge clk);
    chk("R4 irq low masked", irq, 0);
    wr(1'b0, 7'b0000001);
    chk("R6 AL enabled", vec, 1);
    wr(1'b1, 7'h7f);
    @(negedge clk);
  endtask

  task automatic t_collide;
    int v;
    wr(1'b0, 7'h7f);
    pulse(7'b0100000);
    evt_set = 7'b0100000; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 7'b0100000;
    @(negedge clk);
    evt_set = '0; wr_en = 1'b0; wr_data = '0;
    chk("R8 w1c vs set", status, 7'b0100000);
    evt_set = 7'b0100000;
    rd(v);
    evt_set = '0;
    chk("R8 read vs set", status, 7'b0100000);
    chk("R8 vec still", vec, 6);
    wr(1'b1, 7'h7f);
    @(negedge clk);
  endtask

  task automatic t_irq;
    chk("R9 idle", irq, 0);
    pulse(7'b0000001);
    chk("R9 not yet", irq, 0);
    @(negedge clk);
    chk("R9 rise", irq, 1);
    wr(1'b1, 7'b0000001);
    chk("R9 hold", irq, 1);
    @(negedge clk);
    chk("R9 fall", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_map();
    t_drain();
    t_mask();
    t_collide();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule